// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer arithmetic and logic unit for the data-processing instruction group of a load/store processor core. Each cycle it takes a left operand, a right operand that has already passed through the shifter, a 4-bit operation code, a set-flags request, the shifter's carry-out and the four current condition flags (negative, zero, carry, overflow). From these it produces the 32-bit result, a destination write enable and the next value of each flag. It holds no state and needs no clock, so the core's register file and status register capture the outputs at their own edge.

The sixteen operations are eight logical forms, six add/subtract forms and two compare forms. Among the add/subtract forms are the reverse variants, which swap the operand roles, and the carry-chained variants, which take in the current carry. In the subtract family the carry flag means "no borrow". The four test and compare operations always rewrite the flags and never write a destination. Every other operation changes the flags only when set-flags is asserted.

Top module: `dp_alu`

## Requirements
- R1: Opcodes select logical operations as follows: 0 AND (a&b), 1 EOR (a^b), 12 ORR (a|b), 13 MOV (b), 14 BIC (a&~b), 15 MVN (~b). Opcodes 8 (TST) and 9 (TEQ) compute a&b and a^b on `result`.
- R2: Opcode 4 ADD gives a+b and opcode 5 ADC gives a+b+c_in, both modulo 2^32. Opcode 11 (CMN) computes a+b on `result`.
- R3: Opcode 2 SUB gives a-b, opcode 3 RSB gives b-a, opcode 6 SBC gives a-b-(1-c_in) and opcode 7 RSC gives b-a-(1-c_in). Opcode 10 (CMP) computes a-b on `result`.
- R4: `wr_en` is 0 for opcodes 8 to 11 and 1 for every other opcode.
- R5: Whenever flags update, `n_out` equals result bit 31 and `z_out` is 1 exactly when the result is zero.
- R6: For an arithmetic update, `c_out` is the unsigned carry out of bit 31 for additions. For subtractions it is 1 when no borrow occurs, for example a >= b for SUB/CMP.
- R7: For an arithmetic update, `v_out` is 1 exactly when the two's-complement result of the operation overflows 32 bits.
- R8: For a logical update, `c_out` equals `shift_carry` and `v_out` equals `v_in`.
- R9: When `set_flags` is 0 and the opcode is not 8 to 11, all four flag outputs equal their inputs.
- R10: Opcodes 8 to 11 update the flags regardless of `set_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | Left operand |
| op_b | input | 32 | Right operand, already shifted |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request flag update for non-compare operations |
| shift_carry | input | 1 | Shifter carry-out, used as C for logical updates |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Operation result, also driven for compare forms |
| wr_en | output | 1 | Destination write enable |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
The embedded checks act only when opcode, set-flags and both operands are fully known. They also assume that the flag inputs stay steady while the outputs are sampled. The bench meets both conditions: it drives every input to a defined value on the falling clock edge and samples one time unit later, well before the next rising edge. Operands come from a fixed-seed random source mixed with a set of sign-boundary and all-ones values. The carry and overflow inputs are randomised, so each chained and flag-holding path sees both polarities.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic             shift_carry,
  input  logic             n_in,
  input  logic             z_in,
  input  logic             c_in,
  input  logic             v_in,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             n_out,
  output logic             z_out,
  output logic             c_out,
  output logic             v_out
);
  localparam int MSB = WIDTH - 1;

  localparam logic [3:0] OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7;
  localparam logic [3:0] OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11;
  localparam logic [3:0] OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15;

  logic [WIDTH-1:0] add_x, add_y, logic_res;
  logic             add_ci, is_arith;
  logic [WIDTH:0]   sum;

  always_comb begin
    add_x    = op_a;
    add_y    = op_b;
    add_ci   = 1'b0;
    is_arith = 1'b1;
    unique case (opcode)
      OP_SUB, OP_CMP: begin add_y = ~op_b;                add_ci = 1'b1; end
      OP_RSB:         begin add_x = op_b; add_y = ~op_a;  add_ci = 1'b1; end
      OP_ADD, OP_CMN: ;
      OP_ADC:         add_ci = c_in;
      OP_SBC:         begin add_y = ~op_b;                add_ci = c_in; end
      OP_RSC:         begin add_x = op_b; add_y = ~op_a;  add_ci = c_in; end
      default:        is_arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_ci};

  always_comb begin
    unique case (opcode)
      OP_AND, OP_TST: logic_res = op_a & op_b;
      OP_EOR, OP_TEQ: logic_res = op_a ^ op_b;
      OP_ORR:         logic_res = op_a | op_b;
      OP_MOV:         logic_res = op_b;
      OP_BIC:         logic_res = op_a & ~op_b;
      OP_MVN:         logic_res = ~op_b;
      default:        logic_res = '0;
    endcase
  end

  logic is_test, upd, arith_v;

  assign result  = is_arith ? sum[MSB:0] : logic_res;
  assign is_test = opcode[3:2] == 2'b10;
  assign wr_en   = ~is_test;
  assign upd     = set_flags | is_test;
  assign arith_v = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);

  assign n_out = upd ? result[MSB] : n_in;
  assign z_out = upd ? (result == '0) : z_in;
  assign c_out = !upd ? c_in : (is_arith ? sum[WIDTH] : shift_carry);
  assign v_out = !upd ? v_in : (is_arith ? arith_v : v_in);

  always_comb begin
    if (!$isunknown({opcode, set_flags, op_a, op_b, n_in, z_in, c_in, v_in, shift_carry})) begin
      AST_TEST_NO_WRITE: assert ((opcode inside {[4'd8:4'd11]}) == !wr_en); // R4
      AST_FLAGS_HOLD: assert (set_flags || opcode[3:2] == 2'b10 ||
                              {n_out, z_out, c_out, v_out} == {n_in, z_in, c_in, v_in}); // R9
      AST_TEST_UPDATES: assert (opcode[3:2] != 2'b10 || n_out == result[MSB]); // R10
      AST_NZ_TRACK: assert (!(set_flags || is_test) ||
                            (n_out == result[MSB] && z_out == (result == '0))); // R5
      AST_SUB_NO_BORROW: assert (!(upd && (opcode == OP_SUB || opcode == OP_CMP)) ||
                                 c_out == (op_a >= op_b)); // R6
      AST_ADD_OVF: assert (!(upd && (opcode == OP_ADD || opcode == OP_CMN)) ||
                           v_out == (op_a[MSB] == op_b[MSB] && result[MSB] != op_a[MSB])); // R7
      AST_LOGIC_CV: assert (!(upd && (opcode inside {OP_AND, OP_EOR, OP_TST, OP_TEQ,
                                                     OP_ORR, OP_MOV, OP_BIC, OP_MVN})) ||
                            (c_out == shift_carry && v_out == v_in)); // R8
    end
  end
endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a, b, res;
  logic [3:0]  op;
  logic        sf, sc, ni, zi, ci, vi, we, no, zo, co, vo;

  dp_alu dut_i (
    .op_a(a), .op_b(b), .opcode(op), .set_flags(sf), .shift_carry(sc),
    .n_in(ni), .z_in(zi), .c_in(ci), .v_in(vi),
    .result(res), .wr_en(we), .n_out(no), .z_out(zo), .c_out(co), .v_out(vo)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h", req, what, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic s, input logic [4:0] fl);
    logic [31:0] er;
    logic ewe, en, ez, ec, ev, arith, test, upd;
    longint sx, sy, sr;
    longint unsigned ux, uy;
    string rreq, creq, vreq;
    @(negedge clk);
    op = o; a = x; b = y; sf = s; {sc, ni, zi, ci, vi} = fl;
    #1;
    ux = {32'd0, x}; uy = {32'd0, y};
    sx = longint'(signed'(x)); sy = longint'(signed'(y));
    arith = (o inside {[4'd2:4'd7], 4'd10, 4'd11});
    test  = (o inside {[4'd8:4'd11]});
    upd   = s || test;
    ec = 0; sr = 0;
    case (o)
      4'd0, 4'd8:  er = x & y;
      4'd1, 4'd9:  er = x ^ y;
      4'd12:       er = x | y;
      4'd13:       er = y;
      4'd14:       er = x & ~y;
      4'd15:       er = ~y;
      4'd4, 4'd11: begin sr = sx + sy;              ec = (ux + uy) > 64'hFFFF_FFFF; end
      4'd5:        begin sr = sx + sy + ci;         ec = (ux + uy + ci) > 64'hFFFF_FFFF; end
      4'd2, 4'd10: begin sr = sx - sy;              ec = ux >= uy; end
      4'd6:        begin sr = sx - sy - (1 - ci);   ec = ux >= uy + (1 - ci); end
      4'd3:        begin sr = sy - sx;              ec = uy >= ux; end
      default:     begin sr = sy - sx - (1 - ci);   ec = uy >= ux + (1 - ci); end
    endcase
    if (arith) er = sr[31:0];
    ev = arith && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
    ewe = !test;
    if (upd) begin
      en = er[31]; ez = (er == 0);
      if (!arith) begin ec = sc; ev = vi; end
    end else begin
      en = ni; ez = zi; ec = ci; ev = vi;
    end
    rreq = (o inside {4'd4, 4'd5, 4'd11}) ? "R2" :
           (o inside {4'd2, 4'd3, 4'd6, 4'd7, 4'd10}) ? "R3" : "R1";
    creq = !upd ? "R9" : (test && !s) ? "R10" : arith ? "R6" : "R8";
    vreq = !upd ? "R9" : (test && !s) ? "R10" : arith ? "R7" : "R8";
    chk(rreq, "result", res, er);
    chk("R4", "wr_en", {31'd0, we}, {31'd0, ewe});
    chk(upd ? "R5" : "R9", "n", {31'd0, no}, {31'd0, en});
    chk(upd ? "R5" : "R9", "z", {31'd0, zo}, {31'd0, ez});
    chk(creq, "c", {31'd0, co}, {31'd0, ec});
    chk(vreq, "v", {31'd0, vo}, {31'd0, ev});
  endtask

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [6];
    int unsigned seed;
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'h7FFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h8000_0001;
    seed = 32'd1234;
    void'($urandom(seed));
    op = 0; a = 0; b = 0; sf = 0; {sc, ni, zi, ci, vi} = 5'b0;
    // R9: all-zero inputs leave flags clear, R1 AND of zero
    apply(4'd0, 32'd0, 32'd0, 1'b0, 5'b00000);
    // R10/R6: CMP equal operands with set_flags low -> Z=1, C=1
    apply(4'd10, 32'h1234_5678, 32'h1234_5678, 1'b0, 5'b00000);
    // R7: ADD overflow at the positive boundary
    apply(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b1, 5'b00000);
    // R3/R6: SBC with carry clear borrows one extra
    apply(4'd6, 32'd5, 32'd5, 1'b1, 5'b00000);
    // R8: logical update keeps V and takes shifter carry
    apply(4'd15, 32'd0, 32'd0, 1'b1, 5'b10001);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(o[3:0], corner[i], corner[j], $urandom() % 2 == 0, 5'($urandom()));
    for (int k = 0; k < 3000; k++)
      apply(4'($urandom()), $urandom(), $urandom(), 1'($urandom()), 5'($urandom()));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule